// File: doc/BRIEF.md
# Match-Code Address Relocation Unit

This block relocates CPU addresses through a small bank of parallel relocation entries. Each entry holds three registers of `ADDR_W` bits: a mask word, a compare word and an offset word. The low byte of each word concerns an 8-bit mode match code. The remaining upper bits concern the address itself. The match code presented with a lookup first decides which entries are active. Among the active entries, the address is compared under each entry's address mask. The winning entry clears the masked address bits and ORs in its offset. It also supplies an 8-bit control byte that later logic may interpret.

Entries are written through a simple register write port that takes an entry index, a word select and a data word. The lookup itself is combinational. Its results are registered, so the translated address, hit flag, hit index and control byte appear one clock after the address and match code are presented. A constant output reports how many entries the instance was built with.

Top module: `mcode_xlat`

## Requirements
- R1: While reset is asserted and right after it is released, `hit` is 0 and `xlat_addr`, `hit_idx` and `ctrl_byte` are 0. Every entry resets to mask 0 and compare all ones, so no entry can be active until it is written.
- R2: A write with `wr_sel` = 0 loads the mask word, 1 loads the compare word and 2 loads the offset word. In each word, bits 7:0 hold the match-code field and bits `ADDR_W`-1:8 hold the address field. In the offset word, bits 7:0 are the control byte.
- R3: An entry is active only when `match_code` AND its mask bits 7:0 equals its compare bits 7:0.
- R4: An active entry hits only when `addr_in` bits `ADDR_W`-1:8, ANDed with its address mask, equal its address compare field.
- R5: On a hit, `xlat_addr` bits `ADDR_W`-1:8 equal the address bits with the masked bits cleared, ORed with the offset field. `xlat_addr` bits 7:0 always equal `addr_in` bits 7:0.
- R6: When several entries hit, the entry with the lowest index wins, and `hit_idx` carries that index.
- R7: When no entry hits, `hit` is 0, `xlat_addr` equals `addr_in`, and `hit_idx` and `ctrl_byte` are 0.
- R8: On a hit, `ctrl_byte` equals bits 7:0 of the winning entry's offset word.
- R9: Outputs reflect the inputs sampled at the previous rising edge. A register write takes effect for lookups sampled at the following edge, not the edge that performs it.
- R10: `entry_count` always equals the `ENTRIES` parameter.
- R11: A write with `wr_sel` = 3, or with `wr_idx` not below `ENTRIES`, changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | IDX_W | Entry index for the write |
| wr_sel | input | 2 | Word select: 0 mask, 1 compare, 2 offset |
| wr_data | input | ADDR_W | Write data |
| match_code | input | 8 | Current mode match code |
| addr_in | input | ADDR_W | CPU address to translate |
| xlat_addr | output | ADDR_W | Translated address, registered |
| hit | output | 1 | An entry hit, registered |
| hit_idx | output | IDX_W | Index of the winning entry |
| ctrl_byte | output | 8 | Control byte of the winning entry |
| entry_count | output | CNT_W | Number of entries built |

## Verification
The bench builds the unit with `ADDR_W` = 24 and `ENTRIES` = 6. Six is not a power of two, so the 3-bit index reaches the unused codes 6 and 7, and the out-of-range write rejection can be tried. Six entries also let overlapping hits be set up between low, middle and top indices, which exercises the priority order beyond the minimum of four. The 16-bit address field is wide enough to pick masks that separate the compare, clear and OR steps.

// File: rtl/mcx_pkg.sv
package mcx_pkg;
   localparam int MC_W = 8;

   typedef enum logic [1:0] {
      SEL_MASK = 2'd0,
      SEL_CMP  = 2'd1,
      SEL_OFS  = 2'd2,
      SEL_NONE = 2'd3
   } word_sel_e;
endpackage

// File: rtl/mcx_regfile.sv
module mcx_regfile
   import mcx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 4,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] mask_q [ENTRIES],
   output logic [ADDR_W-1:0] cmp_q  [ENTRIES],
   output logic [ADDR_W-1:0] ofs_q  [ENTRIES]
);
   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic sel_me;
      assign sel_me = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            mask_q[e] <= '0;
            cmp_q[e]  <= '1;
            ofs_q[e]  <= '0;
         end else if (sel_me) begin
            unique case (word_sel_e'(wr_sel))
               SEL_MASK: mask_q[e] <= wr_data;
               SEL_CMP:  cmp_q[e]  <= wr_data;
               SEL_OFS:  ofs_q[e]  <= wr_data;
               SEL_NONE: ;
            endcase
         end
      end
   end
endmodule

// File: rtl/mcx_entry_match.sv
module mcx_entry_match
   import mcx_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic [MC_W-1:0]   match_code,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] mask_w,
   input  logic [ADDR_W-1:0] cmp_w,
   output logic              hit
);
   logic mode_ok;
   logic addr_ok;

   assign mode_ok = (match_code & mask_w[MC_W-1:0]) == cmp_w[MC_W-1:0];
   assign addr_ok = (addr[ADDR_W-1:MC_W] & mask_w[ADDR_W-1:MC_W])
                    == cmp_w[ADDR_W-1:MC_W];
   assign hit     = mode_ok && addr_ok;
endmodule

// File: rtl/mcx_prio_pick.sv
module mcx_prio_pick #(
   parameter int ENTRIES = 4,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0] hits,
   output logic               any,
   output logic [IDX_W-1:0]   idx
);
   always_comb begin
      any = |hits;
      idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (hits[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/mcode_xlat.sv
module mcode_xlat
   import mcx_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 4,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
   localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [1:0]        wr_sel,
   input  logic [ADDR_W-1:0] wr_data,
   input  logic [MC_W-1:0]   match_code,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] xlat_addr,
   output logic              hit,
   output logic [IDX_W-1:0]  hit_idx,
   output logic [MC_W-1:0]   ctrl_byte,
   output logic [CNT_W-1:0]  entry_count
);
   if (ENTRIES < 4) begin : g_bad_entries
      $error("mcode_xlat: ENTRIES must be at least 4");
   end
   if (ADDR_W <= MC_W) begin : g_bad_width
      $error("mcode_xlat: ADDR_W must exceed the match-code width");
   end

   logic [ADDR_W-1:0] mask_q [ENTRIES];
   logic [ADDR_W-1:0] cmp_q  [ENTRIES];
   logic [ADDR_W-1:0] ofs_q  [ENTRIES];
   logic [ENTRIES-1:0] ent_hit;
   logic               any_hit;
   logic [IDX_W-1:0]   win_idx;

   mcx_regfile #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .mask_q  (mask_q),
      .cmp_q   (cmp_q),
      .ofs_q   (ofs_q)
   );

   for (genvar e = 0; e < ENTRIES; e++) begin : g_match
      mcx_entry_match #(.ADDR_W(ADDR_W)) u_match (
         .match_code (match_code),
         .addr       (addr_in),
         .mask_w     (mask_q[e]),
         .cmp_w      (cmp_q[e]),
         .hit        (ent_hit[e])
      );
   end

   mcx_prio_pick #(.ENTRIES(ENTRIES)) u_pick (
      .hits (ent_hit),
      .any  (any_hit),
      .idx  (win_idx)
   );

   // Winner's words, then relocation of the upper field only.
   logic [ADDR_W-1:0] win_mask;
   logic [ADDR_W-1:0] win_ofs;
   logic [ADDR_W-1:0] nxt_addr;
   logic [MC_W-1:0]   nxt_ctrl;

   always_comb begin
      win_mask = '0;
      win_ofs  = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (win_idx == IDX_W'(i)) begin
            win_mask = mask_q[i];
            win_ofs  = ofs_q[i];
         end
      end
      if (any_hit) begin
         nxt_addr = {(addr_in[ADDR_W-1:MC_W] & ~win_mask[ADDR_W-1:MC_W])
                     | win_ofs[ADDR_W-1:MC_W],
                     addr_in[MC_W-1:0]};
         nxt_ctrl = win_ofs[MC_W-1:0];
      end else begin
         nxt_addr = addr_in;
         nxt_ctrl = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xlat_addr <= '0;
         hit       <= 1'b0;
         hit_idx   <= '0;
         ctrl_byte <= '0;
      end else begin
         xlat_addr <= nxt_addr;
         hit       <= any_hit;
         hit_idx   <= any_hit ? win_idx : '0;
         ctrl_byte <= nxt_ctrl;
      end
   end

   assign entry_count = CNT_W'(ENTRIES);
endmodule

// File: rtl/mcx_chk.sv
module mcx_chk #(
   parameter int ADDR_W  = 32,
   parameter int ENTRIES = 4,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr_in,
   input logic [ADDR_W-1:0] xlat_addr,
   input logic              hit,
   input logic [IDX_W-1:0]  hit_idx,
   input logic [7:0]        ctrl_byte
);
   logic primed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) primed <= 1'b0;
      else        primed <= 1'b1;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> !hit);

   assert_low_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
      primed |-> xlat_addr[7:0] == $past(addr_in[7:0]));

   assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      hit |-> hit_idx < IDX_W'(ENTRIES));

   assert_miss_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !hit) |-> xlat_addr == $past(addr_in));

   assert_miss_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !hit |-> (hit_idx == '0 && ctrl_byte == '0));
endmodule

bind mcode_xlat mcx_chk #(.ADDR_W(ADDR_W), .ENTRIES(ENTRIES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .addr_in   (addr_in),
   .xlat_addr (xlat_addr),
   .hit       (hit),
   .hit_idx   (hit_idx),
   .ctrl_byte (ctrl_byte)
);

// File: tb/mcode_xlat_tb.sv
`timescale 1ns/1ps
module mcode_xlat_tb;
   localparam int AW = 24;
   localparam int NE = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [1:0]  wr_sel = '0;
   logic [AW-1:0] wr_data = '0;
   logic [7:0]  match_code = '0;
   logic [AW-1:0] addr_in = '0;
   logic [AW-1:0] xlat_addr;
   logic        hit;
   logic [2:0]  hit_idx;
   logic [7:0]  ctrl_byte;
   logic [2:0]  entry_count;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   mcode_xlat #(.ADDR_W(AW), .ENTRIES(NE)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_sel(wr_sel), .wr_data(wr_data), .match_code(match_code),
      .addr_in(addr_in), .xlat_addr(xlat_addr), .hit(hit),
      .hit_idx(hit_idx), .ctrl_byte(ctrl_byte), .entry_count(entry_count)
   );

   typedef struct {
      logic          e_hit;
      logic [2:0]    e_idx;
      logic [AW-1:0] e_addr;
      logic [7:0]    e_ctrl;
      string         tag;
   } exp_t;

   exp_t sb[$];

   task automatic check(input bit ok, input string tag,
                        input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // One cycle: optional write, plus a lookup whose result is expected.
   task automatic cyc(input bit we, input logic [2:0] wi, input logic [1:0] ws,
                      input logic [AW-1:0] wd, input logic [7:0] mc,
                      input logic [AW-1:0] a, input bit push,
                      input logic eh, input logic [2:0] ei,
                      input logic [AW-1:0] ea, input logic [7:0] ec,
                      input string tag);
      exp_t it;
      @(negedge clk);
      wr_en = we; wr_idx = wi; wr_sel = ws; wr_data = wd;
      match_code = mc; addr_in = a;
      if (push) begin
         it.e_hit = eh; it.e_idx = ei; it.e_addr = ea; it.e_ctrl = ec;
         it.tag = tag;
         sb.push_back(it);
      end
   endtask

   task automatic wr(input logic [2:0] i, input logic [1:0] s,
                     input logic [AW-1:0] d);
      cyc(1'b1, i, s, d, 8'h00, '0, 1'b0, 1'b0, '0, '0, '0, "");
   endtask

   task automatic look(input logic [7:0] mc, input logic [AW-1:0] a,
                       input logic eh, input logic [2:0] ei,
                       input logic [AW-1:0] ea, input logic [7:0] ec,
                       input string tag);
      cyc(1'b0, '0, '0, '0, mc, a, 1'b1, eh, ei, ea, ec, tag);
   endtask

   // Monitor: each result appears one edge after its inputs (R9).
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t it;
            it = sb.pop_front();
            check(hit == it.e_hit, {it.tag, " hit"}, 32'(hit), 32'(it.e_hit));
            check(xlat_addr == it.e_addr, {it.tag, " addr"},
                  32'(xlat_addr), 32'(it.e_addr));
            check(hit_idx == it.e_idx, {it.tag, " idx"},
                  32'(hit_idx), 32'(it.e_idx));
            check(ctrl_byte == it.e_ctrl, {it.tag, " ctrl"},
                  32'(ctrl_byte), 32'(it.e_ctrl));
         end
      end
   end

   initial begin
      repeat (50000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      match_code = 8'h00;
      addr_in = 24'h123456;
      repeat (3) @(posedge clk);
      #1;
      check(!hit && xlat_addr == '0, "R1 in reset", 32'(xlat_addr), 0);
      @(negedge clk);
      rst_n = 1'b1;
      check(hit_idx == '0 && ctrl_byte == '0, "R1 after release",
            32'(ctrl_byte), 0);
      check(entry_count == 3'd6, "R10 entry count", 32'(entry_count), 6);

      // R1/R7: nothing programmed, pass through.
      look(8'h00, 24'h123456, 0, 0, 24'h123456, 0, "R1 R7 unprogrammed");
      look(8'hFF, 24'hFFFFFF, 0, 0, 24'hFFFFFF, 0, "R1 R7 all ones");

      // R2: entry 2 mask/compare/offset words.
      wr(3'd2, 2'd0, {16'hFF00, 8'hF0});
      wr(3'd2, 2'd1, {16'h1200, 8'h30});
      wr(3'd2, 2'd2, {16'hAB00, 8'h5A});
      look(8'h3C, 24'h123456, 1, 2, 24'hAB3456, 8'h5A, "R2 R4 R5 R8 entry2 hit");
      look(8'h4C, 24'h123456, 0, 0, 24'h123456, 0, "R3 mode mismatch");
      look(8'h3C, 24'h133456, 0, 0, 24'h133456, 0, "R4 address mismatch");

      // Entry 4 accepts any match code.
      wr(3'd4, 2'd0, {16'hF000, 8'h00});
      wr(3'd4, 2'd1, {16'h1000, 8'h00});
      wr(3'd4, 2'd2, {16'h7000, 8'h11});
      look(8'h3C, 24'h123456, 1, 2, 24'hAB3456, 8'h5A, "R6 entry2 beats entry4");
      look(8'h99, 24'h1F3456, 1, 4, 24'h7F3456, 8'h11, "R3 R5 entry4 any mode");

      // R11: ignored writes.
      wr(3'd4, 2'd3, 24'h000000);
      wr(3'd6, 2'd1, 24'h000000);
      wr(3'd7, 2'd0, 24'h000000);
      look(8'h99, 24'h1F3456, 1, 4, 24'h7F3456, 8'h11, "R11 ignored writes");
      look(8'h01, 24'h803456, 0, 0, 24'h803456, 0, "R11 no alias of idx 6/7");

      // R9: a write and a lookup in the same cycle see the old words.
      cyc(1'b1, 3'd4, 2'd1, {16'h2000, 8'h00}, 8'h99, 24'h1F3456, 1'b1,
          1, 4, 24'h7F3456, 8'h11, "R9 same-cycle old compare");
      look(8'h99, 24'h1F3456, 0, 0, 24'h1F3456, 0, "R9 next-cycle new compare");
      look(8'h99, 24'h2A34FF, 1, 4, 24'h7A34FF, 8'h11, "R5 R9 new compare hit");

      // Entry 5: exact match code, no address mask, pure OR.
      wr(3'd5, 2'd0, {16'h0000, 8'hFF});
      wr(3'd5, 2'd1, {16'h0000, 8'h77});
      wr(3'd5, 2'd2, {16'h8000, 8'hE1});
      look(8'h77, 24'h553456, 1, 5, 24'hD53456, 8'hE1, "R3 R8 top entry");
      look(8'h76, 24'h553456, 0, 0, 24'h553456, 0, "R3 exact mode miss");
      look(8'h77, 24'h2A3456, 1, 4, 24'h7A3456, 8'h11, "R6 entry4 beats entry5");

      // Entry 0 catches everything and wins.
      wr(3'd0, 2'd1, {16'h0000, 8'h00});
      wr(3'd0, 2'd2, {16'h0800, 8'h0F});
      look(8'h77, 24'h553456, 1, 0, 24'h5D3456, 8'h0F, "R6 entry0 wins");
      look(8'h3C, 24'h123400, 1, 0, 24'h1A3400, 8'h0F, "R6 R5 entry0 over entry2");

      cyc(1'b0, '0, '0, '0, 8'h00, '0, 1'b0, 0, 0, 0, 0, "");
      repeat (3) @(negedge clk);
      check(sb.size() == 0, "R9 scoreboard drained", 32'(sb.size()), 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule